// File: doc/BRIEF.md
# Folded Interrupt Aggregator with Power-On Holdoff

This block gathers interrupt sources into one output line. A 32-bit main pending register collects events. Two 32-bit secondary groups feed it. The first group holds endpoint events from a USB core: its lower half carries transmit endpoints and its upper half carries receive endpoints. The second group holds DMA completion flags. Every pending register has its own set, clear and mask access. Each secondary group is reduced to a summary bit inside the main register, and that summary bit follows the group's unmasked state combinationally.

Software chooses the sense of the output line through a polarity bit in a configuration word. Separately, a hardware enable gates the line. When the power input goes from off to on, the enable drops, and it rises again only after a fixed number of clock cycles. During that holdoff the line stays low, whatever is pending. An external level-event port sets or clears a single main bit by its index, so neighbouring logic can raise and withdraw conditions without going through the register bus.

Top module: `irq_fold_top`

## Requirements
- R1: After reset the main pending register is zero and the main mask is all ones. Both group pending registers, both group masks and the configuration word are zero. The output is low.
- R2: Word addresses are 0 to 3 for the main register, 4 to 7 for the endpoint group and 8 to 11 for the DMA group, in the order pending, set, clear, mask. A write to set ORs the data into pending. A write to clear removes the data's one bits. A write to mask stores the data. Reads of pending, set and clear return the pending value, and a read of mask returns the stored mask.
- R3: Main bit 9 reads as one exactly while some endpoint-group bit in 15:0 is pending and unmasked. Main bit 8 does the same for endpoint-group bits 31:16.
- R4: Main bit 24 reads as one exactly while some DMA-group bit is pending and unmasked.
- R5: Main bits 8, 9 and 24 are not changed by main set or clear writes, nor by level events.
- R6: With configuration bit 17 set, the output is high when the enable is up and some main bit is pending and unmasked. With bit 17 clear, the output is high when the enable is up and no main bit is pending and unmasked.
- R7: A rising power input seen while the block is recorded as off drops the enable at that clock edge. The enable returns HOLDOFF_CYC clock edges later.
- R8: A falling power input leaves an already raised enable unchanged. It cancels a holdoff in progress, so the enable stays down until the next power-on holdoff completes.
- R9: A level event with index n and level one sets main bit n. With level zero it clears main bit n. In the same cycle as a main write, the event decides its own bit.
- R10: Word address 12 stores and returns the configuration word. Addresses 13 to 15 read as zero, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register bus |
| addr | input | 4 | Word address shared by reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| evtValid | input | 1 | Level event strobe |
| evtIdx | input | 5 | Main bit index of the level event |
| evtLevel | input | 1 | Level of the event: one sets, zero clears |
| pwrOn | input | 1 | Power state input |
| irqOut | output | 1 | Interrupt output |

## Verification
The bench builds the block with HOLDOFF_CYC set to 16. This brings the power-on holdoff down to a window short enough to check edge by edge, including a power drop in the middle of it and a second power-up. With that holdoff the bench can sweep every main bit, every bit of both groups, and both output polarities against an arithmetic model, so each summary fold and each mask position is checked individually.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;
  localparam int DATA_W      = 32;
  localparam int HALF_W      = DATA_W / 2;
  localparam int ADDR_W      = 4;
  localparam int IDX_W       = $clog2(DATA_W);
  localparam int NUM_GRP     = 2;
  localparam int TX_SUM_BIT  = 9;
  localparam int RX_SUM_BIT  = 8;
  localparam int DMA_SUM_BIT = 24;
  localparam int POL_BIT     = 17;
  localparam logic [DATA_W-1:0] SUM_MASK =
    (DATA_W'(1) << TX_SUM_BIT) | (DATA_W'(1) << RX_SUM_BIT) | (DATA_W'(1) << DMA_SUM_BIT);
  // sub-word offsets inside one four-word register window
  localparam logic [1:0] SUB_PEND = 2'd0;
  localparam logic [1:0] SUB_SET  = 2'd1;
  localparam logic [1:0] SUB_CLR  = 2'd2;
  localparam logic [1:0] SUB_MASK = 2'd3;
  localparam logic [1:0] WIN_MAIN = 2'd0;
  localparam logic [1:0] WIN_CFG  = 2'd3;

  typedef struct packed {
    logic               mainSet;
    logic               mainClr;
    logic               mainMaskWr;
    logic [NUM_GRP-1:0] grpSet;
    logic [NUM_GRP-1:0] grpClr;
    logic [NUM_GRP-1:0] grpMaskWr;
    logic               cfgWr;
  } strobe_t;
endpackage

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl
  import irq_fold_pkg::*;
#(
  parameter int HOLDOFF_CYC = 30000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwrOn,
  output strobe_t           strb,
  output logic              holdEnable
);
  localparam int CNT_W = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLDOFF_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [1:0] win;
  logic [1:0] sub;
  assign win = addr[ADDR_W-1:ADDR_W-2];
  assign sub = addr[1:0];

  // write decode into strobes
  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (win == WIN_MAIN) begin
        strb.mainSet    = (sub == SUB_SET);
        strb.mainClr    = (sub == SUB_CLR);
        strb.mainMaskWr = (sub == SUB_MASK);
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        if (win == 2'(g + 1)) begin
          strb.grpSet[g]    = (sub == SUB_SET);
          strb.grpClr[g]    = (sub == SUB_CLR);
          strb.grpMaskWr[g] = (sub == SUB_MASK);
        end
      end
      strb.cfgWr = (win == WIN_CFG) && (sub == 2'd0);
    end
  end

  // power tracking and holdoff counter
  logic             poweredQ;
  logic             enableQ;
  logic [CNT_W-1:0] holdCnt;
  logic             powerUpEvt;
  assign powerUpEvt = pwrOn && !poweredQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      poweredQ <= 1'b0;
      enableQ  <= 1'b0;
      holdCnt  <= '0;
    end else begin
      poweredQ <= pwrOn;
      if (powerUpEvt) begin
        enableQ <= 1'b0;
        holdCnt <= CNT_LOAD;
      end else if (!pwrOn) begin
        holdCnt <= '0;
      end else if (holdCnt == CNT_ONE) begin
        enableQ <= 1'b1;
        holdCnt <= '0;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - CNT_ONE;
      end
    end
  end
  assign holdEnable = enableQ;

  // R7
  holdoff_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerUpEvt |=> !enableQ);
  // R8
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && !powerUpEvt) |=> enableQ);
  // R8
  off_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrOn && !enableQ) |=> !enableQ);
endmodule

// File: rtl/irq_fold_dp.sv
module irq_fold_dp
  import irq_fold_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              evtValid,
  input  logic [IDX_W-1:0]  evtIdx,
  input  logic              evtLevel,
  input  logic              holdEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] mainStored, mainMask, cfgWord;
  logic [DATA_W-1:0] grpPend [NUM_GRP];
  logic [DATA_W-1:0] grpMask [NUM_GRP];
  logic [DATA_W-1:0] grpLive [NUM_GRP];
  logic [DATA_W-1:0] mainNext, sumBits, mainEff;

  // secondary groups
  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        grpPend[g] <= '0;
        grpMask[g] <= '0;
      end else begin
        if (strb.grpSet[g])    grpPend[g] <= grpPend[g] | wrData;
        if (strb.grpClr[g])    grpPend[g] <= grpPend[g] & ~wrData;
        if (strb.grpMaskWr[g]) grpMask[g] <= wrData;
      end
    end
    assign grpLive[g] = grpPend[g] & ~grpMask[g];
  end

  // fold groups into main summary positions
  always_comb begin
    sumBits = '0;
    sumBits[TX_SUM_BIT]  = |grpLive[0][HALF_W-1:0];
    sumBits[RX_SUM_BIT]  = |grpLive[0][DATA_W-1:HALF_W];
    sumBits[DMA_SUM_BIT] = |grpLive[1];
  end

  // main pending: writes first, then the level event, summary slots kept clear
  always_comb begin
    mainNext = mainStored;
    if (strb.mainSet) mainNext = mainNext | wrData;
    if (strb.mainClr) mainNext = mainNext & ~wrData;
    if (evtValid)     mainNext[evtIdx] = evtLevel;
    mainNext = mainNext & ~SUM_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainStored <= '0;
      mainMask   <= '1;
      cfgWord    <= '0;
    end else begin
      mainStored <= mainNext;
      if (strb.mainMaskWr) mainMask <= wrData;
      if (strb.cfgWr)      cfgWord  <= wrData;
    end
  end

  assign mainEff = mainStored | sumBits;

  // read mux
  logic [1:0] win, sub;
  assign win = rdAddr[ADDR_W-1:ADDR_W-2];
  assign sub = rdAddr[1:0];
  always_comb begin
    rdData = '0;
    if (win == WIN_MAIN) begin
      rdData = (sub == SUB_MASK) ? mainMask : mainEff;
    end else if (win == WIN_CFG) begin
      if (sub == 2'd0) rdData = cfgWord;
    end else begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (win == 2'(g + 1)) rdData = (sub == SUB_MASK) ? grpMask[g] : grpPend[g];
      end
    end
  end

  // output line
  logic anyLive;
  assign anyLive = |(mainEff & ~mainMask);
  assign irqOut  = holdEnable && (cfgWord[POL_BIT] ? anyLive : !anyLive);

  // R2
  main_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mainClr && !evtValid) |=> ((mainStored & $past(wrData)) == '0));
  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtLevel && !SUM_MASK[evtIdx]) |=> mainStored[$past(evtIdx)]);
  // R4
  dma_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mainSet && (grpLive[1] == '0) && (strb.grpSet == '0)) |=> !mainEff[DMA_SUM_BIT]);
endmodule

// File: rtl/irq_fold_top.sv
module irq_fold_top
  import irq_fold_pkg::*;
#(
  parameter int HOLDOFF_CYC = 30000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              evtValid,
  input  logic [IDX_W-1:0]  evtIdx,
  input  logic              evtLevel,
  input  logic              pwrOn,
  output logic              irqOut
);
  strobe_t strb;
  logic    holdEnable;

  irq_fold_ctrl #(.HOLDOFF_CYC(HOLDOFF_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .pwrOn(pwrOn),
    .strb(strb), .holdEnable(holdEnable)
  );

  irq_fold_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdAddr(addr),
    .evtValid(evtValid), .evtIdx(evtIdx), .evtLevel(evtLevel),
    .holdEnable(holdEnable), .rdData(rdData), .irqOut(irqOut)
  );

  // R6
  gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !holdEnable |-> !irqOut);
endmodule

// File: tb/irq_fold_top_tb_top.sv
`timescale 1ns/100ps
module irq_fold_top_tb_top;
  localparam int HOLD = 16;
  localparam logic [31:0] SUMS = (32'd1 << 9) | (32'd1 << 8) | (32'd1 << 24);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic evtValid = 1'b0;
  logic [4:0] evtIdx = '0;
  logic evtLevel = 1'b0;
  logic pwrOn = 1'b0;
  logic irqOut;

  always #2.5 clk = ~clk;

  irq_fold_top #(.HOLDOFF_CYC(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .evtValid(evtValid), .evtIdx(evtIdx), .evtLevel(evtLevel), .pwrOn(pwrOn), .irqOut(irqOut)
  );

  int nChk = 0;
  int nBad = 0;

  // model state
  logic [31:0] mMain = '0, mMask = '1, mCfg = '0;
  logic [31:0] mGrp [2] = '{32'd0, 32'd0};
  logic [31:0] mGMask [2] = '{32'd0, 32'd0};
  logic mEn = 1'b0;

  function automatic logic [31:0] expMain();
    logic [31:0] v, l0, l1;
    l0 = mGrp[0] & ~mGMask[0];
    l1 = mGrp[1] & ~mGMask[1];
    v = mMain & ~SUMS;
    if (l0[15:0] != 0)  v[9] = 1'b1;
    if (l0[31:16] != 0) v[8] = 1'b1;
    if (l1 != 0)        v[24] = 1'b1;
    return v;
  endfunction

  function automatic logic expIrq();
    logic live;
    live = (expMain() & ~mMask) != 0;
    return mEn && (mCfg[17] ? live : !live);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      4'd1: mMain = mMain | d;
      4'd2: mMain = mMain & ~d;
      4'd3: mMask = d;
      4'd5: mGrp[0] = mGrp[0] | d;
      4'd6: mGrp[0] = mGrp[0] & ~d;
      4'd7: mGMask[0] = d;
      4'd9: mGrp[1] = mGrp[1] | d;
      4'd10: mGrp[1] = mGrp[1] & ~d;
      4'd11: mGMask[1] = d;
      4'd12: mCfg = d;
      default: ;
    endcase
    mMain = mMain & ~SUMS;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic evt(input logic [4:0] n, input logic lvl);
    @(negedge clk);
    evtValid = 1'b1; evtIdx = n; evtLevel = lvl;
    @(negedge clk);
    evtValid = 1'b0;
    mMain[n] = lvl;
    mMain = mMain & ~SUMS;
  endtask

  task automatic chkIrq(input string req);
    #1 chk(req, {31'd0, irqOut}, {31'd0, expIrq()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 13; a++) begin
      logic [31:0] e;
      e = (a == 3) ? 32'hffffffff : 32'd0;
      rd(4'(a), v); chk("R1 reset read", v, e);
    end
    chkIrq("R1 reset irq");

    // R7 power-on holdoff, polarity 0 with nothing live => high after holdoff
    @(negedge clk); pwrOn = 1'b1;
    for (int m = 0; m <= HOLD; m++) begin
      @(negedge clk);
      mEn = (m == HOLD);
      chkIrq("R7 holdoff");
    end

    // R2 R5 main set/clear sweep
    for (int i = 0; i < 32; i++) begin
      wr(4'd1, 32'd1 << i);
      rd(4'd0, v); chk("R2 R5 main set", v, expMain());
      rd(4'd1, v); chk("R2 read via set", v, expMain());
      wr(4'd2, 32'd1 << i);
      rd(4'd2, v); chk("R2 main clear", v, expMain());
    end

    // R6 polarity and mask sweep
    for (int p = 0; p < 2; p++) begin
      wr(4'd12, 32'(p) << 17);
      rd(4'd12, v); chk("R10 cfg readback", v, mCfg);
      for (int i = 0; i < 32; i++) begin
        wr(4'd3, ~(32'd1 << i));
        wr(4'd1, 32'd1 << i);
        chkIrq("R6 pending unmasked");
        wr(4'd3, 32'hffffffff);
        chkIrq("R6 all masked");
        wr(4'd2, 32'd1 << i);
      end
    end

    // R3 R4 group fold sweep
    wr(4'd3, 32'd0);
    for (int g = 0; g < 2; g++) begin
      for (int j = 0; j < 32; j++) begin
        logic [3:0] base;
        base = 4'(4 + 4 * g);
        wr(base + 4'd1, 32'd1 << j);
        rd(base + 4'd2, v); chk("R2 group read via clear", v, mGrp[g]);
        rd(4'd0, v); chk(g == 0 ? "R3 fold live" : "R4 fold live", v, expMain());
        chkIrq("R6 fold irq");
        wr(base + 4'd3, 32'd1 << j);
        rd(base + 4'd3, v); chk("R2 group mask read", v, mGMask[g]);
        rd(4'd0, v); chk(g == 0 ? "R3 fold masked" : "R4 fold masked", v, expMain());
        wr(base + 4'd3, 32'd0);
        wr(base + 4'd2, 32'd1 << j);
        rd(base, v); chk("R2 group cleared", v, mGrp[g]);
      end
    end

    // R5 summary slots resist main writes while group live
    wr(4'd5, 32'd1);
    wr(4'd2, SUMS);
    rd(4'd0, v); chk("R5 clear on summary", v, expMain());
    wr(4'd6, 32'd1);
    wr(4'd1, SUMS);
    rd(4'd0, v); chk("R5 set on summary", v, expMain());

    // R9 events
    for (int n = 0; n < 32; n++) begin
      evt(5'(n), 1'b1);
      rd(4'd0, v); chk("R9 R5 event set", v, expMain());
      evt(5'(n), 1'b0);
      rd(4'd0, v); chk("R9 event clear", v, expMain());
    end
    // R9 event wins over same-cycle write
    @(negedge clk);
    wrEn = 1'b1; addr = 4'd1; wrData = 32'h8;
    evtValid = 1'b1; evtIdx = 5'd3; evtLevel = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; evtValid = 1'b0;
    rd(4'd0, v); chk("R9 event priority", v, 32'd0);

    // R10 unmapped
    wr(4'd13, 32'hdeadbeef);
    for (int a = 13; a < 16; a++) begin
      rd(4'(a), v); chk("R10 unmapped read", v, 32'd0);
    end
    rd(4'd12, v); chk("R10 cfg unchanged", v, mCfg);
    rd(4'd0, v); chk("R10 main unchanged", v, expMain());

    // R8 power off keeps enable; polarity 1 with bit 0 live
    wr(4'd1, 32'd1);
    chkIrq("R6 live before power drop");
    @(negedge clk); pwrOn = 1'b0;
    repeat (HOLD + 4) begin
      @(negedge clk); chkIrq("R8 off keeps enable");
    end
    // power up again, then drop mid-holdoff
    @(negedge clk); pwrOn = 1'b1;
    @(negedge clk); mEn = 1'b0; chkIrq("R7 second power-up drops");
    repeat (HOLD / 2) @(negedge clk);
    pwrOn = 1'b0;
    repeat (HOLD + 4) begin
      @(negedge clk); chkIrq("R8 cancelled holdoff");
    end
    @(negedge clk); pwrOn = 1'b1;
    for (int m = 0; m <= HOLD; m++) begin
      @(negedge clk);
      mEn = (m == HOLD);
      chkIrq("R7 holdoff after cancel");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule